// File: doc/BRIEF.md
# UART Interrupt Request Combiner with Sleep-Aware Activity Source

This block turns four UART event conditions into a single active-low interrupt request line. Each condition has its own enable bit. The four conditions are:

- the transmitter has gone fully idle;
- received data is waiting;
- the word at the head of the receive queue carries a set ninth (parity) bit;
- a shared condition whose meaning depends on the power state.

The parity condition lets a host on a 9-bit multidrop network be woken only for address words. Those are the words whose extra bit is 1.

The shared source has two meanings. While the UART runs normally, it mirrors the framing-error status of the character currently being received, and nothing is stored. While the UART is in shutdown, it becomes a receive-activity flag. A small state machine arms this flag on entry to shutdown. The flag is set by any level change on the receive line and cleared when shutdown ends. The serial datapath and the host-side register decode lie outside this block. They supply level status bits and the enable vector.

The state machine has three states:

- `ST_RUN`: normal operation.
- `ST_SLEEP_ARMED`: in shutdown, no receive-line change seen yet.
- `ST_SLEEP_WOKE`: in shutdown, a change has been seen.

Its transitions are:

- RUN to ARMED when `shdn` is sampled high.
- ARMED to WOKE when the synchronized receive line differs from its previous sample.
- ARMED or WOKE back to RUN when `shdn` is sampled low.
- WOKE stays WOKE while `shdn` stays high.

The receive line passes through a `SYNC_STAGES`-deep synchronizer (default 2) before edge detection.

Top module: `irqc_top`

## Requirements
- R1: After reset the state machine is in `ST_RUN`, the shared status output `act_fe_stat` equals `frame_err`, and with all enables clear `irq_n` is 1.
- R2: With `irq_en[0]` set, `irq_n` is 0 whenever `tx_idle` is 1.
- R3: With `irq_en[1]` set, `irq_n` is 0 whenever `fifo_nonempty` is 1.
- R4: The parity source is pending exactly when `fifo_nonempty` and `head_ninth` are both 1, and with `irq_en[2]` set it drives `irq_n` to 0.
- R5: A source whose enable bit is 0 has no effect on `irq_n`; with `irq_en` all zero, `irq_n` is 1 for every input pattern.
- R6: `irq_n` is 0 exactly when at least one pending source has its enable bit set (bit 0 transmit idle, bit 1 data received, bit 2 parity, bit 3 activity/framing), and is otherwise 1.
- R7: Outside shutdown, the shared source and `act_fe_stat` follow `frame_err` combinationally, with no latching: when `frame_err` drops, the shared source drops in the same cycle.
- R8: One clock after `shdn` is sampled high from `ST_RUN`, `act_fe_stat` is 0 and `frame_err` no longer has any effect on it or on `irq_n`.
- R9: In shutdown, a level change on `rx_pin` sets `act_fe_stat` to 1 within `SYNC_STAGES`+2 clocks. The flag remains 1 while shutdown lasts, even after `rx_pin` returns to its earlier level.
- R10: One clock after `shdn` is sampled low, the activity flag is cleared and the block is back in normal operation. A later shutdown starts again with the flag at 0.
- R11: With `irq_en[3]` set, a set activity flag drives `irq_n` to 0; with `irq_en[3]` clear, it does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn | input | 1 | Shutdown request level |
| rx_pin | input | 1 | Raw receive line, idle high |
| tx_idle | input | 1 | Transmit buffer and shift register both empty |
| fifo_nonempty | input | 1 | Receive queue holds at least one word |
| head_ninth | input | 1 | Ninth/parity bit of the word at the receive queue head |
| frame_err | input | 1 | Framing error of the character currently being received |
| irq_en | input | 4 | Source enables: [0] tx idle, [1] data, [2] parity, [3] activity/framing |
| irq_n | output | 1 | Active-low interrupt request |
| act_fe_stat | output | 1 | Shared status bit: framing error when running, activity flag in shutdown |

## Verification
The bench sweeps all 256 combinations of the four status inputs and the four enables in three situations: running, sleeping before any receive activity, and sleeping after activity. The sleeping sweeps toggle `frame_err` freely. A design that still routed framing error into the shared source during shutdown would raise false interrupts or a false status bit there. The bench also returns the receive line to its first level and checks that the activity flag stays set. A design that tracked the line instead of latching would drop the flag. Finally, it leaves and re-enters shutdown and checks that the flag clears and re-arms. A design that forgot to clear on exit would report stale activity. The parity source is also driven with a set ninth bit on an empty queue, where it must stay quiet.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_RUN         = 2'd0,
        ST_SLEEP_ARMED = 2'd1,
        ST_SLEEP_WOKE  = 2'd2
    } sleep_state_e;

    localparam int NUM_SRC      = 4;
    localparam int SRC_TXDONE   = 0;
    localparam int SRC_RXDATA   = 1;
    localparam int SRC_PARITY   = 2;
    localparam int SRC_RXACT_FE = 3;

endpackage

// File: rtl/irqc_rx_sync.sv
module irqc_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_sync,
    output logic rx_edge
);
    logic rx_prev;

    generate
        if (STAGES <= 1) begin : g_single
            logic chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= rx_in;
            end
            assign rx_sync = chain_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], rx_in};
            end
            assign rx_sync = chain_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_prev <= 1'b1;
        else        rx_prev <= rx_sync;
    end

    assign rx_edge = rx_sync ^ rx_prev;

endmodule

// File: rtl/irqc_sleep_fsm.sv
module irqc_sleep_fsm
    import irqc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shdn,
    input  logic         rx_edge,
    output sleep_state_e state,
    output logic         sleeping,
    output logic         act_flag
);
    sleep_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:         if (shdn)         state_d = ST_SLEEP_ARMED;
            ST_SLEEP_ARMED: if (!shdn)        state_d = ST_RUN;
                            else if (rx_edge) state_d = ST_SLEEP_WOKE;
            ST_SLEEP_WOKE:  if (!shdn)        state_d = ST_RUN;
            default:                          state_d = ST_RUN;
        endcase
    end

    always_comb begin
        state    = state_q;
        sleeping = (state_q != ST_RUN);
        act_flag = (state_q == ST_SLEEP_WOKE);
    end

    AST_ENTER_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && shdn) |=> (state_q == ST_SLEEP_ARMED)); // R8
    AST_EDGE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP_ARMED && shdn && rx_edge) |=> (state_q == ST_SLEEP_WOKE)); // R9
    AST_WOKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP_WOKE && shdn) |=> (state_q == ST_SLEEP_WOKE)); // R9
    AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !shdn) |=> (state_q == ST_RUN)); // R10

endmodule

// File: rtl/irqc_src_gate.sv
module irqc_src_gate #(
    parameter int NUM = 4
) (
    input  logic [NUM-1:0] pending,
    input  logic [NUM-1:0] enable,
    output logic           irq_n
);
    logic [NUM-1:0] hit;

    generate
        for (genvar i = 0; i < NUM; i++) begin : g_src
            assign hit[i] = pending[i] & enable[i];
        end
    endgenerate

    assign irq_n = ~(|hit);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shdn,
    input  logic               rx_pin,
    input  logic               tx_idle,
    input  logic               fifo_nonempty,
    input  logic               head_ninth,
    input  logic               frame_err,
    input  logic [NUM_SRC-1:0] irq_en,
    output logic               irq_n,
    output logic               act_fe_stat
);
    logic               rx_sync, rx_edge;
    logic               sleeping, act_flag;
    sleep_state_e       state;
    logic [NUM_SRC-1:0] pending;

    irqc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_in   (rx_pin),
        .rx_sync (rx_sync),
        .rx_edge (rx_edge)
    );

    irqc_sleep_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .shdn     (shdn),
        .rx_edge  (rx_edge),
        .state    (state),
        .sleeping (sleeping),
        .act_flag (act_flag)
    );

    always_comb begin
        act_fe_stat           = sleeping ? act_flag : frame_err;
        pending               = '0;
        pending[SRC_TXDONE]   = tx_idle;
        pending[SRC_RXDATA]   = fifo_nonempty;
        pending[SRC_PARITY]   = fifo_nonempty & head_ninth;
        pending[SRC_RXACT_FE] = act_fe_stat;
    end

    irqc_src_gate #(.NUM(NUM_SRC)) u_gate (
        .pending (pending),
        .enable  (irq_en),
        .irq_n   (irq_n)
    );

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> irq_n); // R5
    AST_TXDONE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en[SRC_TXDONE] && tx_idle) |-> !irq_n); // R2
    AST_RXDATA_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en[SRC_RXDATA] && fifo_nonempty) |-> !irq_n); // R3
    AST_SLEEP_STAT_FROM_FSM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP_ARMED) |-> !act_fe_stat); // R8

endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shdn = 1'b0;
    logic       rx_pin = 1'b1;
    logic       tx_idle = 1'b0;
    logic       fifo_nonempty = 1'b0;
    logic       head_ninth = 1'b0;
    logic       frame_err = 1'b0;
    logic [3:0] irq_en = 4'd0;
    logic       irq_n;
    logic       act_fe_stat;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irqc_top #(.SYNC_STAGES(SYNC)) u_irqc_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .shdn          (shdn),
        .rx_pin        (rx_pin),
        .tx_idle       (tx_idle),
        .fifo_nonempty (fifo_nonempty),
        .head_ninth    (head_ninth),
        .frame_err     (frame_err),
        .irq_en        (irq_en),
        .irq_n         (irq_n),
        .act_fe_stat   (act_fe_stat)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Exhaustive sweep; flag_mode: -1 running (shared = frame_err), 0/1 sleeping flag value
    task automatic sweep(input int flag_mode, input string req);
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 16; m++) begin
                logic [3:0] pend;
                logic       shared;
                tick();
                tx_idle       = p[0];
                fifo_nonempty = p[1];
                head_ninth    = p[2];
                frame_err     = p[3];
                irq_en        = m[3:0];
                shared  = (flag_mode < 0) ? p[3] : flag_mode[0];
                pend    = {shared, p[1] & p[2], p[1], p[0]};
                @(negedge clk);
                check({req, " R6 R5 irq_n"}, irq_n, ~(|(pend & m[3:0])));
                check({req, " stat"}, act_fe_stat, shared);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        @(negedge clk);
        check("R1 irq_n in reset", irq_n, 1'b1);
        check("R1 stat in reset", act_fe_stat, 1'b0);
        tick();
        rst_n = 1'b1;
        tick();
        @(negedge clk);
        check("R1 irq_n after reset", irq_n, 1'b1);
        check("R1 stat after reset", act_fe_stat, 1'b0);

        // R2, R3, R4 directed
        tick(); irq_en = 4'b0001; tx_idle = 1'b1;
        @(negedge clk); check("R2 tx idle fires", irq_n, 1'b0);
        tick(); tx_idle = 1'b0; irq_en = 4'b0010; fifo_nonempty = 1'b1;
        @(negedge clk); check("R3 data fires", irq_n, 1'b0);
        tick(); irq_en = 4'b0100; fifo_nonempty = 1'b0; head_ninth = 1'b1;
        @(negedge clk); check("R4 ninth bit on empty queue quiet", irq_n, 1'b1);
        tick(); fifo_nonempty = 1'b1;
        @(negedge clk); check("R4 address word fires", irq_n, 1'b0);
        tick(); head_ninth = 1'b0;
        @(negedge clk); check("R4 data word quiet", irq_n, 1'b1);

        // R7: framing error is live, not latched
        tick(); fifo_nonempty = 1'b0; irq_en = 4'b1000; frame_err = 1'b1;
        @(negedge clk); check("R7 framing fires", irq_n, 1'b0);
        tick(); frame_err = 1'b0;
        @(negedge clk); check("R7 framing released", irq_n, 1'b1);
        check("R7 stat released", act_fe_stat, 1'b0);

        sweep(-1, "RUN");

        // R8: enter shutdown
        tick(); irq_en = 4'b1000; tx_idle = 0; fifo_nonempty = 0; head_ninth = 0;
        frame_err = 1'b1; shdn = 1'b1;
        tick();
        @(negedge clk);
        check("R8 armed stat clear", act_fe_stat, 1'b0);
        check("R8 framing ignored asleep", irq_n, 1'b1);
        sweep(0, "R8 ARMED");

        // R9: receive activity
        tick(); irq_en = 4'b1000; tx_idle = 0; fifo_nonempty = 0; frame_err = 0;
        rx_pin = 1'b0;
        @(negedge clk); check("R9 no early flag", act_fe_stat, 1'b0);
        repeat (SYNC + 2) tick();
        @(negedge clk);
        check("R9 flag set", act_fe_stat, 1'b1);
        check("R11 flag fires", irq_n, 1'b0);
        tick(); rx_pin = 1'b1;
        repeat (SYNC + 3) tick();
        @(negedge clk);
        check("R9 flag holds after line returns", act_fe_stat, 1'b1);
        tick(); irq_en = 4'b0111;
        @(negedge clk); check("R11 flag masked", irq_n, 1'b1);
        sweep(1, "R9 WOKE");

        // R10: leave shutdown clears flag
        tick(); irq_en = 4'b1000; tx_idle = 0; fifo_nonempty = 0; frame_err = 0;
        shdn = 1'b0;
        tick();
        @(negedge clk);
        check("R10 flag cleared", act_fe_stat, 1'b0);
        check("R10 irq released", irq_n, 1'b1);
        tick(); frame_err = 1'b1;
        @(negedge clk); check("R10 framing meaning restored", act_fe_stat, 1'b1);
        tick(); frame_err = 1'b0; shdn = 1'b1;
        repeat (SYNC + 3) tick();
        @(negedge clk);
        check("R10 re-armed clear", act_fe_stat, 1'b0);
        check("R10 re-armed irq", irq_n, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule